// File: doc/BRIEF.md
# Frame-synced serial PCM port

This block is the digital serial port of a voice codec. It moves one companded 8-bit sample per frame in each direction. A bit clock and a frame sync, nominally at 8 kHz, clock each direction. The transmit side shifts out, most significant bit first, the word its encoder handed over at the previous frame sync. It drives a data line with a separate output enable, so that a pad or a shared bus line can float when the enable is low. It also drives an active-low time-slot strobe while it owns the line. The receive side gathers eight bits and presents them with a one-clock valid pulse. It also raises a flag when the receive sync lasted exactly two bit periods, which tells the decoder that the last bit was stolen for signalling.

All pins are sampled by a single system clock that runs much faster than the bit clocks. Edges are found from those samples, so every pin event reaches the outputs three system clocks later. The width of each transmit frame sync, counted in bit-clock falling edges, selects between two timing formats. One is a single-period "short" sync. The other is a sync of three or more periods, the "long" sync. Both directions use the format chosen. Clock generation and companding sit outside the block.

Top module: `pcm_serial_port`

## Requirements
- R1: After reset, tx_oe is 0, tx_slot_n is 1, rx_valid is 0 and long_mode is 0, so the port starts in the short format.
- R2: long_mode is updated only when tx_fsync falls. It becomes 1 if tx_fsync was high at 3 or more tx_bclk falling edges, and 0 if it was high at 1 or 2 of them.
- R3: In the short format, tx_fsync high at a tx_bclk falling edge starts a slot. tx_oe rises at the next tx_bclk rising edge. It falls at the tx_bclk falling edge that follows the eighth bit, whatever the level of tx_fsync.
- R4: While tx_oe is high, tx_data carries the word most significant bit first. It moves to the next bit only at a tx_bclk rising edge. After the last bit it holds that bit until tx_oe falls. tx_data is 0 while tx_oe is low.
- R5: Each frame sync captures tx_code, and the slot it opens sends the word captured at the frame sync before. The first frame sync after reset only captures, and tx_oe stays 0 for the whole of that frame.
- R6: In the long format, tx_oe rises at the later of the tx_fsync rising edge and the tx_bclk rising edge. If tx_bclk is already high when tx_fsync rises, tx_oe rises at once.
- R7: In the long format, tx_oe falls at the later of two events: the tx_bclk falling edge after the eighth bit, and tx_fsync going low.
- R8: tx_slot_n is the inverse of tx_oe at all times.
- R9: In the short format, rx_fsync high at an rx_bclk falling edge makes the next eight rx_bclk falling edges latch rx_data. The first bit latched is the most significant bit of rx_code.
- R10: In the long format, a rising edge of rx_fsync makes the next eight rx_bclk falling edges latch rx_data, most significant bit first.
- R11: rx_valid is high for exactly one system clock per received word, right after the eighth bit is latched, and rx_code holds that word from then on.
- R12: rx_sig is updated with each received word. It is 1 if rx_fsync for that word was high at exactly two rx_bclk falling edges, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every pin |
| rst_n | input | 1 | Active-low reset |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync; its width selects the format |
| tx_code | input | WORD_W | Encoder word, captured at each transmit frame sync |
| tx_data | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Enable for the transmit data driver |
| tx_slot_n | output | 1 | Active-low strobe that marks the transmit slot |
| long_mode | output | 1 | 1 when the long sync format is in use |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_data | input | 1 | Serial receive data |
| rx_code | output | WORD_W | Last received word |
| rx_valid | output | 1 | One-clock strobe when rx_code is updated |
| rx_sig | output | 1 | Receive sync was two bit periods long |

## Verification
Some rules can be checked on every clock. The enable may only rise on a bit-clock rising edge or a frame-sync rising edge, and may only fall on a bit-clock falling edge or a frame-sync falling edge. Data may only change on a rising bit-clock edge. The enable never rises before the port is primed. The valid strobe lasts one clock and follows a receive falling edge. The format only changes when the transmit sync ends. Other properties can only be shown by whole-frame scenarios in the bench. These are the exact slot position in each format, the "later of" cases, the one-frame delay of the transmitted word, the silent first frame, the order of received bits and the two-period signalling flag. The bench covers all 256 codes in the short format and a spread of codes in the long format.

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int WORD_W   = 8,
  parameter int LONG_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_bclk,
  input  logic              tx_fsync,
  input  logic [WORD_W-1:0] tx_code,
  output logic              tx_data,
  output logic              tx_oe,
  output logic              tx_slot_n,
  output logic              long_mode,
  input  logic              rx_bclk,
  input  logic              rx_fsync,
  input  logic              rx_data,
  output logic [WORD_W-1:0] rx_code,
  output logic              rx_valid,
  output logic              rx_sig
);

  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam int WID_W = $clog2(WORD_W + LONG_MIN + 1);
  localparam logic [WID_W-1:0] WID_MAX = '1;

  // pin sampling: one settling stage, one current stage, one previous stage
  logic [4:0] pin_m, pin_c, pin_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_m <= '0; pin_c <= '0; pin_p <= '0;
    end else begin
      pin_m <= {tx_bclk, tx_fsync, rx_bclk, rx_fsync, rx_data};
      pin_c <= pin_m;
      pin_p <= pin_c;
    end

  logic tb, tf, rb, rf, rd;
  assign {tb, tf, rb, rf, rd} = pin_c;

  logic tb_rise, tb_fall, tf_rise, tf_fall, rb_fall, rf_rise;
  assign tb_rise = tb & ~pin_p[4];
  assign tb_fall = ~tb & pin_p[4];
  assign tf_rise = tf & ~pin_p[3];
  assign tf_fall = ~tf & pin_p[3];
  assign rb_fall = ~rb & pin_p[2];
  assign rf_rise = rf & ~pin_p[1];

  // ---------------- transmit ----------------
  logic              long_q, tx_primed, tx_seen, tx_arm, tx_en, tx_done, tx_fl;
  logic [CNT_W-1:0]  tx_cnt;
  logic [WID_W-1:0]  tx_wid;
  logic [WORD_W-1:0] tx_sh, tx_buf;

  logic tx_trig, end_bits;
  assign tx_trig  = !tx_arm && !tx_en && !tx_seen && (long_q ? tf_rise : (tb_fall && tf));
  assign end_bits = tx_en && tx_cnt == CNT_W'(WORD_W) && tb_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      long_q <= 1'b0; tx_primed <= 1'b0; tx_seen <= 1'b0; tx_arm <= 1'b0;
      tx_en <= 1'b0; tx_done <= 1'b0; tx_fl <= 1'b0; tx_cnt <= '0;
      tx_wid <= '0; tx_sh <= '0; tx_buf <= '0;
    end else begin
      if (tf_rise) tx_wid <= '0;
      else if (tb_fall && tf && tx_wid != WID_MAX) tx_wid <= tx_wid + 1'b1;
      if (tf_fall) long_q <= (tx_wid >= WID_W'(LONG_MIN));
      if (!tf) tx_seen <= 1'b0;

      if (tx_trig) begin
        tx_seen <= 1'b1;
        tx_buf  <= tx_code;
        if (tx_primed) begin
          tx_sh <= tx_buf;
          tx_fl <= long_q;
          if (long_q && tb) begin
            tx_en  <= 1'b1;
            tx_cnt <= CNT_W'(1);
          end else tx_arm <= 1'b1;
        end else tx_primed <= 1'b1;
      end else if (tx_arm && tb_rise) begin
        tx_arm <= 1'b0;
        tx_en  <= 1'b1;
        tx_cnt <= CNT_W'(1);
      end else if (tx_en) begin
        if (tb_rise && tx_cnt != CNT_W'(WORD_W)) begin
          tx_sh  <= tx_sh << 1;
          tx_cnt <= tx_cnt + 1'b1;
        end
        if ((tx_done || end_bits) && (!tx_fl || !tf)) begin
          tx_en   <= 1'b0;
          tx_done <= 1'b0;
          tx_cnt  <= '0;
        end else if (end_bits) tx_done <= 1'b1;
      end
    end

  assign tx_oe     = tx_en;
  assign tx_slot_n = ~tx_en;
  assign tx_data   = tx_en & tx_sh[WORD_W-1];
  assign long_mode = long_q;

  // ---------------- receive ----------------
  logic              rx_seen, rx_act, rx_v, rx_s;
  logic [CNT_W-1:0]  rx_cnt;
  logic [WID_W-1:0]  rx_wid;
  logic [WORD_W-1:0] rx_sh, rx_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_seen <= 1'b0; rx_act <= 1'b0; rx_v <= 1'b0; rx_s <= 1'b0;
      rx_cnt <= '0; rx_wid <= '0; rx_sh <= '0; rx_q <= '0;
    end else begin
      rx_v <= 1'b0;
      if (rf_rise) rx_wid <= '0;
      else if (rb_fall && rf && rx_wid != WID_MAX) rx_wid <= rx_wid + 1'b1;
      if (!rf) rx_seen <= 1'b0;

      if (!rx_act) begin
        if (long_q ? rf_rise : (rb_fall && rf && !rx_seen)) begin
          rx_act  <= 1'b1;
          rx_seen <= 1'b1;
          rx_cnt  <= '0;
        end
      end else if (rb_fall) begin
        rx_sh  <= {rx_sh[WORD_W-2:0], rd};
        rx_cnt <= rx_cnt + 1'b1;
        if (rx_cnt == CNT_W'(WORD_W - 1)) begin
          rx_act <= 1'b0;
          rx_q   <= {rx_sh[WORD_W-2:0], rd};
          rx_v   <= 1'b1;
          rx_s   <= (rx_wid == WID_W'(2));
        end
      end
    end

  assign rx_code  = rx_q;
  assign rx_valid = rx_v;
  assign rx_sig   = rx_s;

  // ---------------- assertions ----------------
  AST_MODE_AT_SYNC_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(long_q) |-> $past(tf_fall)); // R2
  AST_OE_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(tb_rise || tf_rise)); // R6
  AST_OE_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |-> $past(tb_fall || tf_fall)); // R7
  AST_BIT_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (tx_cnt >= CNT_W'(1) && tx_cnt <= CNT_W'(WORD_W))); // R3
  AST_DATA_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && $past(tx_en) && !$stable(tx_data)) |-> $past(tb_rise)); // R4
  AST_NO_DRIVE_UNPRIMED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> tx_primed); // R5
  AST_VALID_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_v |-> $past(rb_fall)); // R9
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_v |=> !rx_v); // R11

endmodule

// File: tb/pcm_serial_port_tb.sv
module pcm_serial_port_tb;
  localparam int CLK_NS = 10;
  localparam int H      = 8;   // system clocks per bit-clock half period
  localparam int NP     = 14;  // bit periods per frame
  localparam int S      = 1;   // period in which the sync starts

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_bclk = 1'b0, tx_fsync = 1'b0, rx_bclk = 1'b0, rx_fsync = 1'b0, rx_data = 1'b0;
  logic [7:0] tx_code = '0;
  logic tx_data, tx_oe, tx_slot_n, long_mode, rx_valid, rx_sig;
  logic [7:0] rx_code;

  always #(CLK_NS/2) clk = ~clk;

  pcm_serial_port u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_bclk(tx_bclk), .tx_fsync(tx_fsync), .tx_code(tx_code),
    .tx_data(tx_data), .tx_oe(tx_oe), .tx_slot_n(tx_slot_n), .long_mode(long_mode),
    .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_data(rx_data),
    .rx_code(rx_code), .rx_valid(rx_valid), .rx_sig(rx_sig)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  bit         mode_l = 0;
  bit         primed = 0;
  logic [7:0] prev_w = '0;

  // receive monitor
  int vcount = 0, vmulti = 0;
  logic [7:0] vcode = '0;
  logic vsig = 1'b0, vprev = 1'b0;
  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin vcount++; vcode = rx_code; vsig = rx_sig; end
    if (rx_valid && vprev) vmulti++;
    vprev = rx_valid;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input int fxlen, input int frlen, input bit late,
                           input logic [7:0] wtx, input logic [7:0] wrx,
                           input string ttag, input string rtag);
    logic [2*NP-1:0] a_oe = '0, e_oe = '0, a_d = '0, e_d = '0, a_sl = '0;
    int e_st, off, q, j, v0, k;
    e_st = (mode_l && !late) ? S : S + 1;
    off  = 2*e_st + 15;
    if (mode_l && 2*(S + fxlen) > off) off = 2*(S + fxlen);
    v0 = vcount;
    tx_code = wtx;
    for (int p = 0; p < NP; p++) begin
      for (int h = 0; h < 2; h++) begin
        q = 2*p + h;
        tx_bclk  = (h == 0);
        rx_bclk  = (h == 0);
        tx_fsync = (p >= S && p < S + fxlen) && !(late && p == S && h == 0);
        rx_fsync = (p >= S && p < S + frlen);
        j = mode_l ? p - S : p - S - 1;
        rx_data = (j >= 0 && j < 8) ? wrx[7-j] : 1'b0;
        if (primed && q >= 2*e_st && q < off) begin
          e_oe[q] = 1'b1;
          k = p - e_st; if (k > 7) k = 7;
          e_d[q] = prev_w[7-k];
        end
        repeat (H) @(negedge clk);
        a_oe[q] = tx_oe; a_d[q] = tx_data; a_sl[q] = tx_slot_n;
      end
    end
    tx_fsync = 1'b0; rx_fsync = 1'b0; rx_data = 1'b0;
    check(a_oe == e_oe, ttag, "enable window", 32'(a_oe), 32'(e_oe));
    check(a_d == e_d, "R4", "data bits", 32'(a_d), 32'(e_d));
    check(a_sl == ~a_oe, "R8", "slot strobe", 32'(a_sl), 32'(~a_oe));
    check(vcount == v0 + 1, "R11", "valid pulses", vcount - v0, 1);
    check(vcode == wrx, rtag, "received word", vcode, wrx);
    check(vsig == (frlen == 2), "R12", "signalling flag", vsig, (frlen == 2));
    check(vmulti == 0, "R11", "valid width", vmulti, 0);
    prev_w = wtx;
    primed = 1;
    mode_l = (fxlen >= 3);
    check(long_mode == mode_l, "R2", "format", long_mode, mode_l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check(tx_oe == 1'b0, "R1", "reset tx_oe", tx_oe, 0);
    check(tx_slot_n == 1'b1, "R1", "reset tx_slot_n", tx_slot_n, 1);
    check(rx_valid == 1'b0, "R1", "reset rx_valid", rx_valid, 0);
    check(long_mode == 1'b0, "R1", "reset format", long_mode, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // first frame only primes the transmitter
    run_frame(1, 1, 0, 8'h3C, 8'h96, "R5", "R9");
    // every code, short format
    for (int c = 0; c < 256; c++)
      run_frame(1, 1, 0, 8'(c), 8'(c) ^ 8'hA5, "R3", "R9");
    // two-period syncs: stays short, flags signalling
    run_frame(2, 2, 0, 8'h81, 8'h7E, "R3", "R12");
    run_frame(2, 1, 0, 8'h42, 8'hC3, "R3", "R9");
    // switch to long (this frame still runs in short timing)
    run_frame(4, 4, 0, 8'hE7, 8'h18, "R3", "R9");
    // long format: coincident, late enable, extended hold
    for (int c = 0; c < 48; c++)
      run_frame(c[1] ? 11 : 4, 4, c[0], 8'(c*37 + 5), 8'(c*91 + 3),
                c[1] ? "R7" : "R6", "R10");
    // one-period sync while long: long timing, then back to short
    run_frame(1, 1, 0, 8'h5A, 8'hF0, "R6", "R10");
    run_frame(1, 1, 0, 8'h0F, 8'h33, "R3", "R9");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule